// File: doc/BRIEF.md
# Reduced-pin Ethernet receive data and carrier/valid presenter

This block sits on the transceiver side of a two-bit-wide Ethernet MAC link. It takes decoded receive nibbles from an elasticity buffer through a valid/ready handshake, together with the buffer's empty flag, an asynchronous carrier indication and a rate select. It drives a two-bit receive data bus and a single combined carrier-sense/data-valid line, all on one 50 MHz reference clock that also serves the transmit direction.

Each nibble goes out as two di-bits, low pair first. At 100 Mbps every di-bit lasts one clock; at 10 Mbps every di-bit is held for ten clocks. The combined line rises as soon as the synchronized carrier shows up. It falls only where a nibble starts. If the carrier has ended while nibbles are still buffered, the line is low on each first di-bit and high on each second di-bit until the buffer is drained. From that pattern the MAC can recover carrier sense and data-valid as two separate signals.

Top module: `rmii_rx_crsdv`

## Requirements
- R1: While reset is held and on the first cycle after it, `crs_dv_o` is 0, `rxd_o` is 00 and `nib_ready_o` is 0.
- R2: The carrier input passes through two synchronizer flops and then the output register. A carrier set before clock edge k gives `crs_dv_o` = 1 after edge k+2 and not before, whatever the di-bit phase.
- R3: While `crs_dv_o` is 1 and no nibble is being presented (before data arrives, or in a gap), `rxd_o` reads 00.
- R4: A nibble is presented as `nib_data_i[1:0]` in one di-bit slot, then as `nib_data_i[3:2]` in the next slot. A slot lasts 1 clock when `speed_100_i` = 1 and 10 clocks when `speed_100_i` = 0.
- R5: While the carrier is present, `crs_dv_o` stays 1 through every di-bit of the received data.
- R6: `crs_dv_o` falls only at the end of a slot that completes a nibble or a gap slot, so that its low value starts on a nibble boundary.
- R7: When the carrier has ended and nibbles remain, `crs_dv_o` is 0 on each first (low) di-bit and 1 on each second (high) di-bit.
- R8: A carrier with no data (a false carrier) holds `crs_dv_o` at 1 and `rxd_o` at 00 for the whole carrier activity.
- R9: Once the carrier is gone and the buffer is empty, `crs_dv_o` goes to 0 and `rxd_o` to 00 at the next nibble boundary, and both stay there.
- R10: `nib_ready_o` pulses only at a nibble boundary with `nib_valid_i` = 1. Each pulse takes exactly one nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100_i | input | 1 | 1 = 100 Mbps (1 clock per di-bit), 0 = 10 Mbps (10 clocks per di-bit) |
| carrier_i | input | 1 | Asynchronous carrier-detect indication |
| nib_valid_i | input | 1 | Buffer offers a decoded nibble |
| nib_data_i | input | 4 | Offered nibble |
| buf_empty_i | input | 1 | Elasticity buffer holds no more bits |
| nib_ready_o | output | 1 | Nibble taken on this clock edge |
| rxd_o | output | 2 | Receive di-bit to the MAC |
| crs_dv_o | output | 1 | Combined carrier sense / data valid |

## Verification
Call the edge where `crs_dv_o` first rises E0. That edge falls two synchronizer edges plus one output-register edge after the carrier is set, and the bench confirms the line is still low one edge before E0. Slot k after E0 covers clocks E0+k·D to E0+(k+1)·D−1, with D of 1 or 10. Slot 0 is the zero-data gap, and slot 1+2i+j carries di-bit j of nibble i. The bench samples every clock of each slot at the falling edge against that arithmetic. The end-of-frame and false-carrier drops are checked once the worst-case synchronizer-plus-slot delay has passed.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
    localparam int DIBIT_W = 2;
    localparam int NIB_W   = 2 * DIBIT_W;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_GAP    = 2'd1,
        PH_FIRST  = 2'd2,
        PH_SECOND = 2'd3
    } rx_phase_e;

    typedef struct packed {
        rx_phase_e          ph;
        logic [DIBIT_W-1:0] rxd;
        logic [DIBIT_W-1:0] hi;
        logic               crs;
    } seq_regs_t;
endpackage

// File: rtl/rx_carrier_sync.sv
module rx_carrier_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign chain_d[g] = async_i;
            end else begin : g_tail
                assign chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_slot_timer.sv
module rx_slot_timer #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic speed_100_i,
    output logic slot_end_o
);
    localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        slot_end_o = speed_100_i || (cnt_q == LAST);
        cnt_d      = cnt_q;
        if (!run_i || slot_end_o) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R4
    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> cnt_q == '0); // R4
endmodule

// File: rtl/rx_dibit_sequencer.sv
module rx_dibit_sequencer
    import rmii_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               car_s_i,
    input  logic               slot_end_i,
    input  logic               nib_valid_i,
    input  logic [NIB_W-1:0]   nib_data_i,
    input  logic               buf_empty_i,
    output logic               nib_ready_o,
    output logic               run_o,
    output logic [DIBIT_W-1:0] rxd_o,
    output logic               crs_o
);
    seq_regs_t r_d, r_q;
    logic      boundary;

    always_comb begin
        r_d         = r_q;
        nib_ready_o = 1'b0;
        boundary    = slot_end_i && (r_q.ph == PH_GAP || r_q.ph == PH_SECOND);

        case (r_q.ph)
            PH_IDLE: begin
                r_d.rxd = '0;
                if (car_s_i) begin
                    r_d.ph  = PH_GAP;
                    r_d.crs = 1'b1;
                end
            end
            PH_GAP: begin
                if (car_s_i) r_d.crs = 1'b1;
            end
            PH_FIRST: begin
                if (slot_end_i) begin
                    r_d.ph  = PH_SECOND;
                    r_d.rxd = r_q.hi;
                    r_d.crs = 1'b1;
                end
            end
            default: ;
        endcase

        if (boundary) begin
            if (nib_valid_i) begin
                nib_ready_o = 1'b1;
                r_d.ph      = PH_FIRST;
                r_d.rxd     = nib_data_i[DIBIT_W-1:0];
                r_d.hi      = nib_data_i[NIB_W-1:DIBIT_W];
                r_d.crs     = car_s_i;
            end else if (car_s_i || !buf_empty_i) begin
                r_d.ph  = PH_GAP;
                r_d.rxd = '0;
                r_d.crs = car_s_i;
            end else begin
                r_d.ph  = PH_IDLE;
                r_d.rxd = '0;
                r_d.crs = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ph  <= PH_IDLE;
            r_q.rxd <= '0;
            r_q.hi  <= '0;
            r_q.crs <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_o = (r_q.ph != PH_IDLE);
    assign rxd_o = r_q.rxd;
    assign crs_o = r_q.crs;

    AST_RISE_FROM_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.crs) && r_q.ph != PH_SECOND) |-> $past(car_s_i)); // R2
    AST_GAP_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_GAP) |-> (r_q.rxd == '0)); // R3
    AST_FALL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.crs) |-> ($past(slot_end_i) && $past(r_q.ph == PH_GAP || r_q.ph == PH_SECOND))); // R6
    AST_SECOND_HALF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_SECOND) |-> r_q.crs); // R7
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        nib_ready_o |-> (nib_valid_i && slot_end_i)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_IDLE) |-> (!r_q.crs && r_q.rxd == '0)); // R9
endmodule

// File: rtl/rmii_rx_crsdv.sv
module rmii_rx_crsdv
    import rmii_rx_pkg::*;
#(
    parameter int SLOW_DIV    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             speed_100_i,
    input  logic             carrier_i,
    input  logic             nib_valid_i,
    input  logic [NIB_W-1:0] nib_data_i,
    input  logic             buf_empty_i,
    output logic             nib_ready_o,
    output logic [DIBIT_W-1:0] rxd_o,
    output logic             crs_dv_o
);
    logic car_s;
    logic slot_end;
    logic run;

    rx_carrier_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (carrier_i),
        .sync_o  (car_s)
    );

    rx_slot_timer #(.SLOW_DIV(SLOW_DIV)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .speed_100_i (speed_100_i),
        .slot_end_o  (slot_end)
    );

    rx_dibit_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .car_s_i     (car_s),
        .slot_end_i  (slot_end),
        .nib_valid_i (nib_valid_i),
        .nib_data_i  (nib_data_i),
        .buf_empty_i (buf_empty_i),
        .nib_ready_o (nib_ready_o),
        .run_o       (run),
        .rxd_o       (rxd_o),
        .crs_o       (crs_dv_o)
    );
endmodule

// File: tb/tb_rmii_rx_crsdv.sv
module tb_rmii_rx_crsdv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_100 = 1'b1;
    logic       carrier = 1'b0;
    logic [3:0] fifo [16];
    int         wr_n = 0;
    int         rd_i = 0;
    logic       nib_valid;
    logic [3:0] nib_data;
    logic       buf_empty;
    logic       nib_ready;
    logic [1:0] rxd;
    logic       crs_dv;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign nib_valid = rd_i < wr_n;
    assign nib_data  = fifo[rd_i % 16];
    assign buf_empty = !nib_valid;

    always @(posedge clk) if (nib_ready) rd_i <= rd_i + 1;

    rmii_rx_crsdv dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed_100_i (speed_100),
        .carrier_i   (carrier),
        .nib_valid_i (nib_valid),
        .nib_data_i  (nib_data),
        .buf_empty_i (buf_empty),
        .nib_ready_o (nib_ready),
        .rxd_o       (rxd),
        .crs_dv_o    (crs_dv)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One frame of n nibbles; drain=1 drops the carrier right after CRS_DV rises.
    task automatic run_frame(input bit spd, input bit drain, input int n);
        int d;
        int start;
        logic [3:0] v [8];
        d = spd ? 1 : 10;
        @(negedge clk);
        speed_100 = spd;
        start = wr_n;
        for (int i = 0; i < n; i++) begin
            v[i] = 4'((i * 5 + int'(spd) * 3 + int'(drain) * 9 + 1) % 16);
            fifo[(wr_n + i) % 16] = v[i];
        end
        wr_n = wr_n + n;
        carrier = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 not yet high", int'(crs_dv), 0);
        @(posedge clk); // E0
        for (int c = 0; c < (1 + 2 * n + 2) * d; c++) begin
            int k;
            @(negedge clk);
            k = c / d;
            if (k == 0) begin
                check("R2 crs high", int'(crs_dv), 1);
                check("R3 gap rxd zero", int'(rxd), 0);
            end else if (k <= 2 * n) begin
                int m;
                int i;
                int j;
                m = k - 1;
                i = m / 2;
                j = m % 2;
                check("R4 dibit order", int'(rxd), int'((v[i] >> (2 * j)) & 4'h3));
                if (!drain) check("R5 crs during data", int'(crs_dv), 1);
                else if (i >= 1) check("R7 drain toggle", int'(crs_dv), j);
            end else begin
                check("R3 rxd zero after data", int'(rxd), 0);
                if (drain) check("R9 end low", int'(crs_dv), 0);
                else       check("R5 carrier still high", int'(crs_dv), 1);
            end
            if (drain && c == 0) carrier = 1'b0;
            @(posedge clk);
        end
        check("R10 nibbles taken", rd_i - start, n);
        if (!drain) begin
            @(negedge clk);
            carrier = 1'b0;
            repeat (3 + d) @(posedge clk);
        end
        repeat (5) begin
            @(negedge clk);
            check("R9 stays low", int'(crs_dv), 0);
            check("R9 rxd idle", int'(rxd), 0);
        end
    endtask

    task automatic false_carrier(input bit spd, input int len);
        int d;
        d = spd ? 1 : 10;
        @(negedge clk);
        speed_100 = spd;
        carrier = 1'b1;
        repeat (3) @(posedge clk);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            check("R8 false carrier crs", int'(crs_dv), 1);
            check("R8 false carrier rxd", int'(rxd), 0);
            check("R10 no ready on empty", int'(nib_ready), 0);
        end
        carrier = 1'b0;
        repeat (3 + d) @(posedge clk);
        @(negedge clk);
        check("R9 false carrier ends", int'(crs_dv), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 crs reset", int'(crs_dv), 0);
        check("R1 rxd reset", int'(rxd), 0);
        check("R1 ready reset", int'(nib_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 crs after reset", int'(crs_dv), 0);
        check("R1 rxd after reset", int'(rxd), 0);
        for (int s = 0; s < 2; s++) begin
            run_frame(s == 0, 1'b0, 5);
            run_frame(s == 0, 1'b1, 4);
            false_carrier(s == 0, 37);
        end
        run_frame(1'b1, 1'b0, 1);
        run_frame(1'b0, 1'b1, 2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule